// File: doc/BRIEF.md
# Clock Output Stop Gating Controller

This block sits between free-running source clocks and the output buffers of a clock generator. It gates four clock families: CPU, PCI, SDRAM and AGP. Each gated output either copies its source clock or is parked at logic 0. Three active-low stop requests (CPU, PCI, SDRAM) park whole families, but only in mobile mode. A mode input chooses between desktop and mobile behaviour. In desktop mode the four SDRAM outputs whose pins double as control inputs run as ordinary SDRAM clocks. In mobile mode those pins are held low so that they can serve as inputs.

Every output also has its own enable bit, supplied by a configuration register file outside this block. Some outputs are exempt from stop requests:

- One PCI output is never stopped.
- The two AGP outputs are never stopped.
- A select bit lets the last CPU output ignore its stop request.

Each stop request passes through a two-flop synchroniser in its target clock domain. The gate state of an output changes only on a falling edge of the source clock. As a result, every high pulse that leaves the block is a full half period wide.

Top module: `clkstop_ctrl`

## Requirements
- R1: An output whose enable bit is 0 is held at logic 0 for the whole source period and does not switch.
- R2: With `mode_mobile`=0, the three stop inputs have no effect: an enabled CPU, PCI or SDRAM output keeps running even while its stop input is 0.
- R3: With `mode_mobile`=1, `cpu_stop_n`=0 parks the CPU outputs. Timing: a level set after source rising edge P0 is captured at edges P1 and P2 and takes effect at the falling edge after P2. The output therefore still pulses at P1 and P2 and stays low from P3 on. Release follows the same lag.
- R4: With `mode_mobile`=1, `pci_stop_n`=0 parks every bit of `pci_out`, while `pci_free_out` keeps running.
- R5: With `mode_mobile`=1, `sdram_stop_n`=0 parks every bit of `sdram_out`.
- R6: When `cpu_free_sel`=1, the highest CPU output (index NCPU-1) keeps running while the CPU stop is in effect. When `cpu_free_sel`=0, it obeys the stop.
- R7: The AGP outputs follow only their enable bits. No stop input and no mode value parks them.
- R8: The shared SDRAM outputs run in desktop mode when enabled, and are held at 0 throughout mobile mode.
- R9: Glitch-free gating: every output high pulse lasts exactly half a source period, and the output is low whenever the source clock is low.
- R10: While `rst_n`=0, every output is 0 and the stop synchronisers hold the deasserted level.
- R11: A change of an enable bit, made after rising edge P0, takes effect at the following falling edge. The output at edge P1 already reflects the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mobile | input | 1 | 1 = mobile (stops obeyed, shared pins idle), 0 = desktop |
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | PCI source clock |
| sdram_clk | input | 1 | SDRAM source clock |
| agp_clk | input | 1 | AGP source clock |
| cpu_stop_n | input | 1 | Active-low CPU stop request |
| pci_stop_n | input | 1 | Active-low PCI stop request |
| sdram_stop_n | input | 1 | Active-low SDRAM stop request |
| cpu_en | input | NCPU | Per-output CPU enables |
| cpu_free_sel | input | 1 | 1 = last CPU output ignores the CPU stop |
| pci_free_en | input | 1 | Enable of the free-running PCI output |
| pci_en | input | NPCI | Enables of the stoppable PCI outputs |
| sdram_en | input | NSDR | Enables of the regular SDRAM outputs |
| shared_en | input | NSHR | Enables of the shared-pin SDRAM outputs |
| agp_en | input | NAGP | AGP enables |
| cpu_out | output | NCPU | Gated CPU clocks |
| pci_free_out | output | 1 | Free-running gated PCI clock |
| pci_out | output | NPCI | Stoppable gated PCI clocks |
| sdram_out | output | NSDR | Gated SDRAM clocks |
| shared_out | output | NSHR | Gated SDRAM clocks on shared pins |
| agp_out | output | NAGP | Gated AGP clocks |

## Verification
Each stop input is driven low first in desktop mode, then in mobile mode. This separates the mode qualification (R2) from the stop action itself (R3, R4, R5). With the CPU stop in effect, `cpu_free_sel` is toggled, which separates the exempt CPU output from the others (R6). A single stop assertion is sampled on three successive rising edges to pin down the synchroniser lag. Stop and enable changes are then scattered across many phases of the four unrelated source clocks. A reference model and a pulse-width monitor together catch any early or late gating and any shortened pulse.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/100ps
package clkstop_pkg;

  // An output may run when enabled and no applicable stop is in effect.
  function automatic logic run_allowed(input logic en, input logic mobile,
                                       input logic stop_act, input logic exempt);
    return en & ~(mobile & stop_act & ~exempt);
  endfunction

endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/100ps
module clkstop_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  output logic stop_act
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], req_n};
  end

  assign stop_act = ~chain[STAGES-1];

  generate
    if (STAGES == 2) begin : g_lag_chk
      // R3: the synchronised stop lags the request by exactly two edges
      p_sync_lag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (stop_act == !$past(req_n, 2)));
    end
  endgenerate
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/100ps
module clkstop_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic gclk
);
  logic run_q;

  // Gate state changes only on the falling edge, while the source is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  assign gclk = clk & run_q;
endmodule

// File: rtl/clkstop_group.sv
`timescale 1ns/100ps
module clkstop_group #(
  parameter int N           = 1,
  parameter bit HAS_STOP    = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mobile,
  input  logic         stop_req_n,
  input  logic [N-1:0] en,
  input  logic [N-1:0] exempt,
  output logic [N-1:0] gclk,
  output logic         stop_act
);
  localparam logic USE_STOP = HAS_STOP;

  logic         sync_stop;
  logic [N-1:0] run;

  clkstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_n   (stop_req_n),
    .stop_act(sync_stop)
  );

  assign stop_act = sync_stop & USE_STOP;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      run[i] = clkstop_pkg::run_allowed(en[i], mobile, stop_act, exempt[i]);
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_cell
      clkstop_gate u_gate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run[g]),
        .gclk (gclk[g])
      );
    end
  endgenerate
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/100ps
module clkstop_ctrl #(
  parameter int NCPU = 3,
  parameter int NPCI = 5,
  parameter int NSDR = 9,
  parameter int NSHR = 4,
  parameter int NAGP = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            rst_n,
  input  logic            mode_mobile,
  input  logic            cpu_clk,
  input  logic            pci_clk,
  input  logic            sdram_clk,
  input  logic            agp_clk,
  input  logic            cpu_stop_n,
  input  logic            pci_stop_n,
  input  logic            sdram_stop_n,
  input  logic [NCPU-1:0] cpu_en,
  input  logic            cpu_free_sel,
  input  logic            pci_free_en,
  input  logic [NPCI-1:0] pci_en,
  input  logic [NSDR-1:0] sdram_en,
  input  logic [NSHR-1:0] shared_en,
  input  logic [NAGP-1:0] agp_en,
  output logic [NCPU-1:0] cpu_out,
  output logic            pci_free_out,
  output logic [NPCI-1:0] pci_out,
  output logic [NSDR-1:0] sdram_out,
  output logic [NSHR-1:0] shared_out,
  output logic [NAGP-1:0] agp_out
);
  localparam int NPCI_ALL = NPCI + 1;

  // Named internal events, brought out for the assertions
  logic cpu_stop_act, pci_stop_act, sdram_stop_act, shr_stop_act, agp_stop_act;
  logic [NCPU-1:0]     cpu_exempt;
  logic [NPCI_ALL-1:0] pci_all_en, pci_all_exempt, pci_all_out;
  logic [NSHR-1:0]     shr_live_en;

  assign cpu_exempt     = {cpu_free_sel, {(NCPU-1){1'b0}}};
  assign pci_all_en     = {pci_en, pci_free_en};
  assign pci_all_exempt = {{NPCI{1'b0}}, 1'b1};
  assign shr_live_en    = shared_en & {NSHR{~mode_mobile}};

  clkstop_group #(.N(NCPU), .HAS_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_cpu (
    .clk(cpu_clk), .rst_n(rst_n), .mobile(mode_mobile), .stop_req_n(cpu_stop_n),
    .en(cpu_en), .exempt(cpu_exempt), .gclk(cpu_out), .stop_act(cpu_stop_act));

  clkstop_group #(.N(NPCI_ALL), .HAS_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_pci (
    .clk(pci_clk), .rst_n(rst_n), .mobile(mode_mobile), .stop_req_n(pci_stop_n),
    .en(pci_all_en), .exempt(pci_all_exempt), .gclk(pci_all_out), .stop_act(pci_stop_act));

  assign pci_free_out = pci_all_out[0];
  assign pci_out      = pci_all_out[NPCI_ALL-1:1];

  clkstop_group #(.N(NSDR), .HAS_STOP(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_sdr (
    .clk(sdram_clk), .rst_n(rst_n), .mobile(mode_mobile), .stop_req_n(sdram_stop_n),
    .en(sdram_en), .exempt({NSDR{1'b0}}), .gclk(sdram_out), .stop_act(sdram_stop_act));

  clkstop_group #(.N(NSHR), .HAS_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_shr (
    .clk(sdram_clk), .rst_n(rst_n), .mobile(mode_mobile), .stop_req_n(1'b1),
    .en(shr_live_en), .exempt({NSHR{1'b1}}), .gclk(shared_out), .stop_act(shr_stop_act));

  clkstop_group #(.N(NAGP), .HAS_STOP(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_agp (
    .clk(agp_clk), .rst_n(rst_n), .mobile(mode_mobile), .stop_req_n(1'b1),
    .en(agp_en), .exempt({NAGP{1'b1}}), .gclk(agp_out), .stop_act(agp_stop_act));

  // ---------------- assertions (sampled mid high phase via negedge) ----------
  generate
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu_chk
      localparam bit IS_LAST = (i == NCPU-1);
      p_cpu_stop_r3: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_mobile) && $past(cpu_stop_act) && !IS_LAST) |-> !cpu_out[i]);
      p_cpu_free_sel_r6: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        ($past(rst_n) && IS_LAST && $past(cpu_free_sel)) |-> (cpu_out[i] == $past(cpu_en[i])));
      p_cpu_disabled_r1: assert property (@(negedge cpu_clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cpu_en[i])) |-> !cpu_out[i]);
    end
    for (genvar i = 0; i < NPCI; i++) begin : g_pci_chk
      p_pci_stop_r4: assert property (@(negedge pci_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_mobile) && $past(pci_stop_act)) |-> !pci_out[i]);
    end
    for (genvar i = 0; i < NSDR; i++) begin : g_sdr_chk
      p_sdram_stop_r5: assert property (@(negedge sdram_clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_mobile) && $past(sdram_stop_act)) |-> !sdram_out[i]);
    end
    for (genvar i = 0; i < NAGP; i++) begin : g_agp_chk
      p_agp_follow_r7: assert property (@(negedge agp_clk) disable iff (!rst_n)
        $past(rst_n) |-> (agp_out[i] == $past(agp_en[i])));
    end
  endgenerate

  p_pci_free_runs_r4: assert property (@(negedge pci_clk) disable iff (!rst_n)
    $past(rst_n) |-> (pci_free_out == $past(pci_free_en)));
  p_desktop_ignores_stop_r2: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(mode_mobile)) |-> (cpu_out == $past(cpu_en)));
  p_shared_idle_mobile_r8: assert property (@(negedge sdram_clk) disable iff (!rst_n)
    ($past(rst_n) && $past(mode_mobile)) |-> (shared_out == '0));
  p_no_stop_without_pin_r7: assert property (@(posedge agp_clk) disable iff (!rst_n)
    !agp_stop_act && !shr_stop_act);
endmodule

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/100ps
module test_clkstop_ctrl;
  localparam int NCPU = 3, NPCI = 5, NSDR = 9, NSHR = 4, NAGP = 2;

  logic rst_n = 1'b0, mode_mobile = 1'b0;
  logic cpu_clk = 1'b0, pci_clk = 1'b0, sdram_clk = 1'b0, agp_clk = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sdram_stop_n = 1'b1;
  logic [NCPU-1:0] cpu_en = '1;
  logic            cpu_free_sel = 1'b0, pci_free_en = 1'b1;
  logic [NPCI-1:0] pci_en = '1;
  logic [NSDR-1:0] sdram_en = '1;
  logic [NSHR-1:0] shared_en = '1;
  logic [NAGP-1:0] agp_en = '1;
  logic [NCPU-1:0] cpu_out;
  logic            pci_free_out;
  logic [NPCI-1:0] pci_out;
  logic [NSDR-1:0] sdram_out;
  logic [NSHR-1:0] shared_out;
  logic [NAGP-1:0] agp_out;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  clkstop_ctrl i_clkstop_ctrl (.*);

  // 250 MHz CPU clock; other sources at unrelated periods
  always #2 cpu_clk   = ~cpu_clk;
  always #3 sdram_clk = ~sdram_clk;
  always #5 pci_clk   = ~pci_clk;
  always #4 agp_clk   = ~agp_clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pchk(input string tag, input realtime w, input realtime half);
    checks++;
    if (w < half - 0.05 || w > half + 0.05) begin
      errors++;
      $display("FAIL %s pulse width actual %0.2f expected %0.2f at %0t", tag, w, half, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit cpu_q[$] = '{1'b1, 1'b1};
  bit pci_q[$] = '{1'b1, 1'b1};
  bit sdr_q[$] = '{1'b1, 1'b1};
  logic [NCPU-1:0] cpu_exp = '0;
  logic            pfree_exp = 1'b0;
  logic [NPCI-1:0] pci_exp = '0;
  logic [NSDR-1:0] sdr_exp = '0;
  logic [NSHR-1:0] shr_exp = '0;
  logic [NAGP-1:0] agp_exp = '0;

  always @(posedge cpu_clk or negedge rst_n)
    if (!rst_n) cpu_q = '{1'b1, 1'b1};
    else begin cpu_q.push_back(cpu_stop_n); void'(cpu_q.pop_front()); end
  always @(posedge pci_clk or negedge rst_n)
    if (!rst_n) pci_q = '{1'b1, 1'b1};
    else begin pci_q.push_back(pci_stop_n); void'(pci_q.pop_front()); end
  always @(posedge sdram_clk or negedge rst_n)
    if (!rst_n) sdr_q = '{1'b1, 1'b1};
    else begin sdr_q.push_back(sdram_stop_n); void'(sdr_q.pop_front()); end

  always @(negedge cpu_clk or negedge rst_n)
    for (int i = 0; i < NCPU; i++) begin
      bit halted;
      halted = mode_mobile && !cpu_q[0] && !(i == NCPU-1 && cpu_free_sel);
      cpu_exp[i] = rst_n && cpu_en[i] && !halted;
    end
  always @(negedge pci_clk or negedge rst_n) begin
    pfree_exp = rst_n && pci_free_en;
    for (int i = 0; i < NPCI; i++)
      pci_exp[i] = rst_n && pci_en[i] && !(mode_mobile && !pci_q[0]);
  end
  always @(negedge sdram_clk or negedge rst_n) begin
    for (int i = 0; i < NSDR; i++)
      sdr_exp[i] = rst_n && sdram_en[i] && !(mode_mobile && !sdr_q[0]);
    for (int i = 0; i < NSHR; i++)
      shr_exp[i] = rst_n && shared_en[i] && !mode_mobile;
  end
  always @(negedge agp_clk or negedge rst_n)
    for (int i = 0; i < NAGP; i++) agp_exp[i] = rst_n && agp_en[i];

  // ---------------- per-clock comparison (high and low phase) ----------------
  always @(posedge cpu_clk) begin #0.5; chk("R1/R3/R6/R11 cpu", 16'(cpu_out), 16'(cpu_exp)); end
  always @(posedge pci_clk) begin #0.5;
    chk("R4 pci_free", 16'(pci_free_out), 16'(pfree_exp));
    chk("R4/R1 pci", 16'(pci_out), 16'(pci_exp)); end
  always @(posedge sdram_clk) begin #0.5;
    chk("R5/R1 sdram", 16'(sdram_out), 16'(sdr_exp));
    chk("R8 shared", 16'(shared_out), 16'(shr_exp)); end
  always @(posedge agp_clk) begin #0.5; chk("R7 agp", 16'(agp_out), 16'(agp_exp)); end
  always @(negedge cpu_clk) begin #0.5; chk("R9 cpu low", 16'(cpu_out), 16'h0); end
  always @(negedge pci_clk) begin #0.5; chk("R9 pci low", 16'({pci_out, pci_free_out}), 16'h0); end
  always @(negedge sdram_clk) begin #0.5; chk("R9 sdram low", 16'({shared_out, sdram_out}), 16'h0); end

  // ---------------- pulse width monitor (R9) ----------------
  logic [NCPU-1:0] cpu_prev = '0;
  realtime cpu_rise [NCPU];
  always @(cpu_out) begin
    for (int i = 0; i < NCPU; i++) begin
      if (cpu_out[i] && !cpu_prev[i]) cpu_rise[i] = $realtime;
      else if (!cpu_out[i] && cpu_prev[i]) pchk("R9 cpu", $realtime - cpu_rise[i], 2.0);
    end
    cpu_prev = cpu_out;
  end
  logic [NPCI:0] pci_prev = '0;
  realtime pci_rise [NPCI+1];
  always @(pci_out or pci_free_out) begin
    for (int i = 0; i <= NPCI; i++) begin
      logic cur;
      cur = (i == 0) ? pci_free_out : pci_out[i-1];
      if (cur && !pci_prev[i]) pci_rise[i] = $realtime;
      else if (!cur && pci_prev[i]) pchk("R9 pci", $realtime - pci_rise[i], 5.0);
      pci_prev[i] = cur;
    end
  end
  logic [NSDR+NSHR-1:0] sdr_prev = '0;
  realtime sdr_rise [NSDR+NSHR];
  always @(sdram_out or shared_out) begin
    for (int i = 0; i < NSDR+NSHR; i++) begin
      logic cur;
      cur = (i < NSDR) ? sdram_out[i] : shared_out[i-NSDR];
      if (cur && !sdr_prev[i]) sdr_rise[i] = $realtime;
      else if (!cur && sdr_prev[i]) pchk("R9 sdram", $realtime - sdr_rise[i], 3.0);
      sdr_prev[i] = cur;
    end
  end
  logic [NAGP-1:0] agp_prev = '0;
  realtime agp_rise [NAGP];
  always @(agp_out) begin
    for (int i = 0; i < NAGP; i++) begin
      if (agp_out[i] && !agp_prev[i]) agp_rise[i] = $realtime;
      else if (!agp_out[i] && agp_prev[i]) pchk("R9 agp", $realtime - agp_rise[i], 4.0);
    end
    agp_prev = agp_out;
  end

  // ---------------- watchdog ----------------
  always @(posedge cpu_clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge cpu_clk);
    #0.3;
  endtask

  task automatic at_high(input int n);  // n-th cpu rising edge, mid high phase
    repeat (n) @(posedge cpu_clk);
    #0.5;
  endtask

  initial begin
    step(5);
    chk("R10 reset outputs", 16'({cpu_out, pci_out, pci_free_out, agp_out}), 16'h0);
    chk("R10 reset sdram", 16'({shared_out, sdram_out}), 16'h0);
    rst_n = 1'b1;
    step(12);
    @(posedge sdram_clk); #0.5;
    chk("R2 shared run desktop", 16'(shared_out), 16'hF);

    // desktop: stops low must be ignored
    step(1);
    cpu_stop_n = 1'b0; pci_stop_n = 1'b0; sdram_stop_n = 1'b0;
    at_high(12);
    chk("R2 cpu ignores stop", 16'(cpu_out), 16'h7);
    @(posedge sdram_clk); #0.5;
    chk("R2 sdram ignores stop", 16'(sdram_out), 16'h1FF);

    // mobile: stops obeyed
    step(1);
    mode_mobile = 1'b1;
    at_high(12);
    chk("R3 cpu stopped", 16'(cpu_out), 16'h0);
    @(posedge pci_clk); #0.5;
    chk("R4 pci stopped", 16'(pci_out), 16'h0);
    chk("R4 pci free runs", 16'(pci_free_out), 16'h1);
    @(posedge sdram_clk); #0.5;
    chk("R5 sdram stopped", 16'(sdram_out), 16'h0);
    chk("R8 shared idle", 16'(shared_out), 16'h0);
    @(posedge agp_clk); #0.5;
    chk("R7 agp runs", 16'(agp_out), 16'h3);

    step(1);
    cpu_free_sel = 1'b1;
    at_high(3);
    chk("R6 last cpu free", 16'(cpu_out), 16'h4);
    step(1);
    cpu_free_sel = 1'b0;
    at_high(3);
    chk("R6 last cpu obeys", 16'(cpu_out), 16'h0);

    // release and synchroniser lag
    step(1);
    cpu_stop_n = 1'b1; pci_stop_n = 1'b1; sdram_stop_n = 1'b1;
    at_high(6);
    chk("R3 cpu restarted", 16'(cpu_out), 16'h7);
    step(1);
    cpu_stop_n = 1'b0;
    at_high(1); chk("R3 lag edge1", 16'(cpu_out), 16'h7);
    at_high(1); chk("R3 lag edge2", 16'(cpu_out), 16'h7);
    at_high(1); chk("R3 lag edge3", 16'(cpu_out), 16'h0);
    step(1);
    cpu_stop_n = 1'b1;
    at_high(4);

    // enable timing and disabled outputs
    step(1);
    cpu_en = 3'b110;
    at_high(1); chk("R11 enable next edge", 16'(cpu_out), 16'h6);
    step(1);
    cpu_en = 3'b010; agp_en = 2'b01;
    at_high(2); chk("R1 cpu disabled", 16'(cpu_out), 16'h2);
    @(posedge agp_clk); #0.5;
    chk("R7 agp enable only", 16'(agp_out), 16'h1);

    // scattered stop/enable/mode activity across clock phases
    for (int k = 0; k < 400; k++) begin
      step((k % 5) + 1);
      case (k % 7)
        0: cpu_stop_n   = ~cpu_stop_n;
        1: pci_stop_n   = ~pci_stop_n;
        2: sdram_stop_n = ~sdram_stop_n;
        3: cpu_en       = cpu_en ^ 3'(k);
        4: begin pci_en = pci_en ^ 5'(k); sdram_en = sdram_en ^ 9'(k * 3); end
        5: begin cpu_free_sel = ~cpu_free_sel; agp_en = agp_en ^ 2'(k); end
        default: if (k % 3 == 0) mode_mobile = ~mode_mobile;
      endcase
    end
    step(20);
    finish_run();
  end
endmodule